// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a sparse two-level page table held in ordinary memory. The top bits of the virtual address pick a slot in a root table, and the entry found there names the frame of a second-level table. The middle bits pick a slot in that second table, and that entry names the frame of the data page. The low bits pass through as the byte offset. The root table's frame number sits in a register inside the block, and software loads it through a write strobe.

Each memory access goes through a word-read port with a request/acknowledge handshake and a separate response strobe. A walk makes at most two reads. If the root-level entry is not present, the walk stops after one read, because the second-level table does not exist. If either entry is not present, the block raises a one-cycle fault interrupt. That interrupt reports the virtual address that failed and the level at which it failed. A successful walk ends with a one-cycle completion strobe that carries the physical address.

Top module: `pgw_top`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_req_valid`, `done_valid` and `fault_irq` are 0. The root frame register resets to 0.
- R2: The first read goes to address (root frame << 12) + 4 × VA[31:22].
- R3: The second read goes to address (first entry bits 31:12 << 12) + 4 × VA[21:12]. Bit 0 of an entry is its present flag, and bits 31:12 hold its frame number.
- R4: When the second entry is present, `done_valid` is high for exactly one cycle. At the same time `done_paddr` equals (second entry bits 31:12 << 12) | VA[11:0].
- R5: When the first entry has bit 0 clear, `fault_irq` pulses for one cycle with `fault_level` = 0 and `fault_vaddr` = VA. No second read is issued.
- R6: When the second entry has bit 0 clear, `fault_irq` pulses for one cycle with `fault_level` = 1 and `fault_vaddr` = VA, after exactly two reads.
- R7: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R8: `req_ready` is high only while idle. A request is taken only when `req_valid` and `req_ready` are both high, and `req_valid` has no effect during a walk.
- R9: A write through `root_we` changes the root frame used by every later walk.
- R10: Virtual address 0x00403004 walks through root slot 1 (address root+0x4) and second-level slot 3 (address +0xC), and keeps offset 0x004.

Port reference: the table below lists the ports of `pgw_top` in the order of its port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load strobe for the root frame register |
| root_frame_in | input | 20 | New root table frame number |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned |
| done_valid | output | 1 | One-cycle translation success strobe |
| done_paddr | output | 32 | Translated physical address |
| fault_irq | output | 1 | One-cycle page-fault interrupt |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_level | output | 1 | Faulting level: 0 root, 1 second |

## Verification
The assertions assume three things about the inputs:
- The memory acknowledges a read only while `mem_req_valid` is high.
- The memory returns exactly one response, and only in a later cycle than the acknowledge.
- The root register is written only while the walker is idle, so the request address cannot change while it is held.

The bench models the memory inside each walk task in that order. It raises the acknowledge only after it sees a request, and it pulses the response on the next cycle. It loads the root frame only between walks. During a stalled acknowledge, it also drives a stray request to check that the request is ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_L1,
      ST_READ_L2,
      ST_DONE,
      ST_FAULT
   } pgw_state_e;

   localparam logic LVL_ROOT   = 1'b0;
   localparam logic LVL_SECOND = 1'b1;
endpackage

// File: rtl/pgw_ent_addr.sv
// Forms the byte address of one table entry from a table frame and an index.
module pgw_ent_addr #(
   parameter int PA_W        = 32,
   parameter int FR_W        = 20,
   parameter int IDX_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [FR_W-1:0]  tbl_frame,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  ent_addr
);
   localparam int ESH = $clog2(ENTRY_BYTES);

   logic [PA_W-1:0] base_w;
   logic [PA_W-1:0] slot_w;

   assign base_w   = {tbl_frame, {OFF_W{1'b0}}};
   assign slot_w   = PA_W'(idx) << ESH;
   assign ent_addr = base_w | slot_w;
endmodule

// File: rtl/pgw_entry_dec.sv
// Splits a table entry into its present flag and frame number.
module pgw_entry_dec #(
   parameter int ENT_W = 32,
   parameter int OFF_W = 12,
   parameter int FR_W  = 20
) (
   input  logic [ENT_W-1:0] ent,
   output logic             present,
   output logic [FR_W-1:0]  frame
);
   logic unused_bits;

   assign present     = ent[0];
   assign frame       = ent[OFF_W +: FR_W];
   assign unused_bits = ^ent[OFF_W-1:1];
endmodule

// File: rtl/pgw_ctrl.sv
// Walk sequencer: one read per level, request held until acknowledged.
module pgw_ctrl
   import pgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       mem_ack,
   input  logic       mem_rsp,
   input  logic       ent_present,
   output pgw_state_e state,
   output logic       issue,
   output logic       take_l1,
   output logic       take_l2,
   output logic       flt,
   output logic       flt_lvl
);
   pgw_state_e state_d;
   logic       issued_q;
   logic       issued_d;
   logic       reading;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         issued_q <= 1'b0;
      end else begin
         state    <= state_d;
         issued_q <= issued_d;
      end
   end

   assign reading = (state == ST_READ_L1) || (state == ST_READ_L2);
   assign issue   = reading && !issued_q;

   always_comb begin
      state_d  = state;
      issued_d = issued_q;
      take_l1  = 1'b0;
      take_l2  = 1'b0;
      flt      = 1'b0;
      flt_lvl  = LVL_ROOT;
      case (state)
         ST_IDLE: begin
            if (start) begin
               state_d  = ST_READ_L1;
               issued_d = 1'b0;
            end
         end
         ST_READ_L1: begin
            if (issue && mem_ack) begin
               issued_d = 1'b1;
            end else if (issued_q && mem_rsp) begin
               if (ent_present) begin
                  take_l1  = 1'b1;
                  issued_d = 1'b0;
                  state_d  = ST_READ_L2;
               end else begin
                  flt      = 1'b1;
                  flt_lvl  = LVL_ROOT;
                  issued_d = 1'b0;
                  state_d  = ST_FAULT;
               end
            end
         end
         ST_READ_L2: begin
            if (issue && mem_ack) begin
               issued_d = 1'b1;
            end else if (issued_q && mem_rsp) begin
               issued_d = 1'b0;
               if (ent_present) begin
                  take_l2 = 1'b1;
                  state_d = ST_DONE;
               end else begin
                  flt     = 1'b1;
                  flt_lvl = LVL_SECOND;
                  state_d = ST_FAULT;
               end
            end
         end
         ST_DONE:  state_d = ST_IDLE;
         ST_FAULT: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
   import pgw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int L1_W        = 10,
   parameter int L2_W        = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int ENT_W       = 32,
   parameter logic [PA_W-OFF_W-1:0] ROOT_RESET = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  root_we,
   input  logic [PA_W-OFF_W-1:0] root_frame_in,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_vaddr,
   output logic                  req_ready,
   output logic                  mem_req_valid,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_req_ready,
   input  logic                  mem_rsp_valid,
   input  logic [ENT_W-1:0]      mem_rsp_data,
   output logic                  done_valid,
   output logic [PA_W-1:0]       done_paddr,
   output logic                  fault_irq,
   output logic [VA_W-1:0]       fault_vaddr,
   output logic                  fault_level
);
   localparam int FR_W = PA_W - OFF_W;
   localparam int IW   = (L1_W > L2_W) ? L1_W : L2_W;
   localparam int NLVL = 2;

   generate
      if (VA_W != L1_W + L2_W + OFF_W) begin : g_bad_split
         $error("virtual address width must equal both index widths plus offset");
      end
      if (ENT_W != 8 * ENTRY_BYTES) begin : g_bad_entry
         $error("entry width must match entry byte count");
      end
      if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("entry byte count must be a power of two");
      end
      if (ENT_W < OFF_W + FR_W) begin : g_bad_frame
         $error("entry too narrow for a frame number");
      end
      if (((1 << IW) * ENTRY_BYTES) > (1 << OFF_W)) begin : g_bad_fit
         $error("a table must fit in one frame");
      end
   endgenerate

   pgw_state_e          state;
   logic                issue;
   logic                take_l1;
   logic                take_l2;
   logic                flt;
   logic                flt_lvl;
   logic                start;
   logic                ent_present;
   logic [FR_W-1:0]     ent_frame;
   logic [FR_W-1:0]     root_q;
   logic [VA_W-1:0]     va_q;
   logic [FR_W-1:0]     l2_tbl_q;
   logic [PA_W-1:0]     pa_q;
   logic                lvl_q;
   logic [FR_W-1:0]     tbl_frame [NLVL];
   logic [IW-1:0]       tbl_idx   [NLVL];
   logic [PA_W-1:0]     lvl_addr  [NLVL];

   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root_q <= ROOT_RESET;
      end else if (root_we) begin
         root_q <= root_frame_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q     <= '0;
         l2_tbl_q <= '0;
         pa_q     <= '0;
         lvl_q    <= LVL_ROOT;
      end else begin
         if (start) begin
            va_q <= req_vaddr;
         end
         if (take_l1) begin
            l2_tbl_q <= ent_frame;
         end
         if (take_l2) begin
            pa_q <= {ent_frame, va_q[OFF_W-1:0]};
         end
         if (flt) begin
            lvl_q <= flt_lvl;
         end
      end
   end

   assign tbl_frame[0] = root_q;
   assign tbl_frame[1] = l2_tbl_q;
   assign tbl_idx[0]   = IW'(va_q[VA_W-1 -: L1_W]);
   assign tbl_idx[1]   = IW'(va_q[OFF_W +: L2_W]);

   generate
      for (genvar g = 0; g < NLVL; g++) begin : g_lvl
         pgw_ent_addr #(
            .PA_W        (PA_W),
            .FR_W        (FR_W),
            .IDX_W       (IW),
            .OFF_W       (OFF_W),
            .ENTRY_BYTES (ENTRY_BYTES)
         ) i_addr (
            .tbl_frame (tbl_frame[g]),
            .idx       (tbl_idx[g]),
            .ent_addr  (lvl_addr[g])
         );
      end
   endgenerate

   pgw_entry_dec #(
      .ENT_W (ENT_W),
      .OFF_W (OFF_W),
      .FR_W  (FR_W)
   ) i_dec (
      .ent     (mem_rsp_data),
      .present (ent_present),
      .frame   (ent_frame)
   );

   pgw_ctrl i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mem_ack     (mem_req_ready),
      .mem_rsp     (mem_rsp_valid),
      .ent_present (ent_present),
      .state       (state),
      .issue       (issue),
      .take_l1     (take_l1),
      .take_l2     (take_l2),
      .flt         (flt),
      .flt_lvl     (flt_lvl)
   );

   assign mem_req_valid = issue;
   assign mem_req_addr  = (state == ST_READ_L2) ? lvl_addr[1] : lvl_addr[0];
   assign done_valid    = (state == ST_DONE);
   assign done_paddr    = pa_q;
   assign fault_irq     = (state == ST_FAULT);
   assign fault_vaddr   = va_q;
   assign fault_level   = lvl_q;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int ENT_W       = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  mem_req_valid,
   input logic [PA_W-1:0]       mem_req_addr,
   input logic                  mem_req_ready,
   input logic                  done_valid,
   input logic                  fault_irq
);
   // R7: held request keeps its address until acknowledged
   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R8: an idle walker issues nothing and reports nothing
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid && !done_valid && !fault_irq);

   // R8: a taken request makes the walker busy
   a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R4: completion lasts one cycle and returns to idle
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid && req_ready);

   // R5, R6: fault lasts one cycle and returns to idle
   a_r6_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault_irq |=> !fault_irq && req_ready);

   // R5: success and fault never coincide
   a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && fault_irq));
endmodule

bind pgw_top pgw_chk #(
   .VA_W  (VA_W),
   .PA_W  (PA_W),
   .OFF_W (OFF_W),
   .ENT_W (ENT_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .done_valid    (done_valid),
   .fault_irq     (fault_irq)
);

// File: tb/test_pgw_top.sv
`timescale 1ns/1ps
module test_pgw_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [19:0] root_frame_in = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [31:0] done_paddr;
   logic        fault_irq;
   logic [31:0] fault_vaddr;
   logic        fault_level;

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [logic [31:0]];

   always #4 clk = ~clk;

   pgw_top i_pgw_top (
      .clk           (clk),
      .rst_n         (rst_n),
      .root_we       (root_we),
      .root_frame_in (root_frame_in),
      .req_valid     (req_valid),
      .req_vaddr     (req_vaddr),
      .req_ready     (req_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done_valid    (done_valid),
      .done_paddr    (done_paddr),
      .fault_irq     (fault_irq),
      .fault_vaddr   (fault_vaddr),
      .fault_level   (fault_level)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // One walk with a bench-modelled memory. Checks addresses, result and read count.
   task automatic run_walk(input string tag, input logic [31:0] va, input int stall,
                           input bit poke, input int exp_reads,
                           input logic [31:0] exp_a1, input logic [31:0] exp_a2,
                           input bit exp_fault, input logic exp_lvl,
                           input logic [31:0] exp_pa);
      int reads = 0;
      bit fin = 0;
      bit seen_done = 0;
      bit seen_fault = 0;
      int busy_bad = 0;
      int hold_bad = 0;
      logic [31:0] a;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
         bit moved = 0;
         if (done_valid || fault_irq) begin
            fin = 1;
            seen_done  = done_valid;
            seen_fault = fault_irq;
            if (done_valid) chk("R4", {tag, " paddr"}, done_paddr, exp_pa);
            if (fault_irq) begin
               chk("R5", {tag, " fault vaddr"}, fault_vaddr, va);
               chk("R6", {tag, " fault level"}, 32'(fault_level), 32'(exp_lvl));
            end
         end else begin
            if (req_ready) busy_bad++;
            if (mem_req_valid) begin
               a = mem_req_addr;
               reads++;
               if (reads == 1) chk("R2", {tag, " first read addr"}, a, exp_a1);
               if (reads == 2) chk("R3", {tag, " second read addr"}, a, exp_a2);
               for (int s = 0; s < stall; s++) begin
                  if (poke) begin
                     req_valid = 1'b1;
                     req_vaddr = 32'hDEAD_BEEF;
                  end
                  @(negedge clk);
                  if (!mem_req_valid || mem_req_addr !== a) hold_bad++;
                  if (req_ready) busy_bad++;
               end
               req_valid = 1'b0;
               mem_req_ready = 1'b1;
               @(negedge clk);
               mem_req_ready = 1'b0;
               mem_rsp_valid = 1'b1;
               mem_rsp_data = rd(a);
               @(negedge clk);
               mem_rsp_valid = 1'b0;
               mem_rsp_data = '0;
               moved = 1;
            end
         end
         if (!fin && !moved) @(negedge clk);
      end
      chk("R4", {tag, " ended with done"}, 32'(seen_done), 32'(!exp_fault));
      chk("R5", {tag, " ended with fault"}, 32'(seen_fault), 32'(exp_fault));
      chk("R6", {tag, " read count"}, reads, exp_reads);
      chk("R7", {tag, " request held while stalled"}, hold_bad, 0);
      chk("R8", {tag, " busy while walking"}, busy_bad, 0);
      @(negedge clk);
      chk("R8", {tag, " idle after walk"}, 32'(req_ready), 32'd1);
      chk("R8", {tag, " no walk from stray request"}, 32'(mem_req_valid), 32'd0);
      chk("R4", {tag, " strobes one cycle"}, 32'(done_valid | fault_irq), 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_ready", 32'(req_ready), 32'd1);
      chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
      chk("R1", "done_valid", 32'(done_valid), 32'd0);
      chk("R1", "fault_irq", 32'(fault_irq), 32'd0);
   endtask

   task automatic t_example();
      // R10: slot 1 then slot 3 with root at reset value 0 (R1)
      run_walk("R10 example", 32'h0040_3004, 0, 0, 2, 32'h0000_0004, 32'h0001_000C,
               0, 1'b0, 32'h0ABC_D004);
   endtask

   task automatic t_high_slots();
      run_walk("R7 stalled high slots", 32'hFFC0_1ABC, 3, 1, 2, 32'h0000_0FFC,
               32'h0002_0004, 0, 1'b0, 32'h1234_5ABC);
   endtask

   task automatic t_root_fault();
      run_walk("R5 root absent", 32'h0080_0000, 2, 0, 1, 32'h0000_0008, 32'h0,
               1, 1'b0, 32'h0);
   endtask

   task automatic t_second_fault();
      run_walk("R6 second absent", 32'h0040_5000, 0, 0, 2, 32'h0000_0004,
               32'h0001_0014, 1, 1'b1, 32'h0);
   endtask

   task automatic t_root_change();
      @(negedge clk);
      root_we = 1'b1;
      root_frame_in = 20'h00100;
      @(negedge clk);
      root_we = 1'b0;
      run_walk("R9 new root", 32'h0040_3004, 1, 0, 2, 32'h0010_0004, 32'h0004_000C,
               0, 1'b0, 32'h0077_7004);
   endtask

   initial begin
      mem[32'h0000_0004] = 32'h0001_0001;
      mem[32'h0001_000C] = 32'h0ABC_D001;
      mem[32'h0000_0FFC] = 32'h0002_0001;
      mem[32'h0002_0004] = 32'h1234_5001;
      mem[32'h0000_0008] = 32'h0003_0000;
      mem[32'h0001_0014] = 32'h0FFF_F000;
      mem[32'h0010_0004] = 32'h0004_0001;
      mem[32'h0004_000C] = 32'h0077_7001;
      t_reset();
      t_example();
      t_high_slots();
      t_root_fault();
      t_second_fault();
      t_root_change();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule